// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire serial slave engine and a nonvolatile memory array. The slave engine opens a write command with a start address, then delivers data bytes one strobe at a time. Each byte lands in a one-page staging buffer at the current pointer offset. The pointer advances only inside the page, so a long burst wraps and overwrites bytes received earlier. A mask records which offsets were loaded.

When the engine reports a Stop, the block samples the write-protect input. If protection is off and at least one byte was loaded, the block raises `busy` for a timed interval. During that interval it walks the page once in offset order and drives one array write for each loaded offset. If protection is on, if the command carried no data, or if the command was abandoned by a repeated Start, the staged bytes are dropped. In those cases there is no busy interval and the block is ready again at once. The address pointer always ends one past the last byte received, so a following read continues from there.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `arrWe` are 0 and `ptrOut` is 0.
- R2: When no commit is in progress, `cmdStart` loads `ptrOut` with `startAddr` and opens a command, discarding anything staged before.
- R3: Each accepted data byte advances only the low log2(PAGE_BYTES) bits of `ptrOut`, wrapping within the page. The upper bits never change.
- R4: If more than PAGE_BYTES bytes arrive in one command, a later byte at the same page offset replaces the earlier one, and only the last value reaches the array.
- R5: A Stop with `wpIn` low and at least one staged byte raises `busy` on the next cycle. `busy` then stays high for exactly max(BUSY_CYCLES, PAGE_BYTES) cycles.
- R6: While busy, the block issues one `arrWe` pulse per loaded offset and none for unloaded offsets. The pulses come in ascending offset order. `arrAddr` carries the page bits of the pointer joined with the offset, and `arrData` carries the last byte staged there.
- R7: `wpIn` matters only in the Stop cycle. If it is high then, no array write and no busy interval follow. Changing `wpIn` after a Stop leaves a running commit unaffected.
- R8: A `cmdAbort` (repeated Start) or a new `cmdStart` before Stop starts no write and no busy interval. The abandoned bytes are never written, and an abort leaves `ptrOut` where the bytes moved it.
- R9: While `busy` is high, `byteWr`, `cmdStart`, `cmdAbort` and `stopStrb` are ignored: `ptrOut` holds, and bytes offered then are never written.
- R10: A Stop after a command that carried no data bytes starts no busy interval and leaves `ptrOut` at the start address.
- R11: `arrWe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Open a write command at `startAddr` |
| startAddr | input | ADDR_W | Start address for the command |
| byteWr | input | 1 | One data byte is offered on `byteData` |
| byteData | input | 8 | Data byte |
| stopStrb | input | 1 | Stop seen on the bus |
| cmdAbort | input | 1 | Repeated Start: close the command without writing |
| wpIn | input | 1 | Write protect, sampled at Stop |
| busy | output | 1 | Commit interval in progress |
| ptrOut | output | ADDR_W | Current internal address pointer |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | 8 | Array write data |

## Verification
The bench builds the block with ADDR_W = 12, PAGE_BYTES = 16 and BUSY_CYCLES = 40. With a 16-byte page, offset wrap and overflow past a full page take only a handful of strobes, so random bursts of up to 32 bytes hit both cases often. A 4 KiB address space lets the bench keep a full mirror of the array and compare all of it after every command. With a short busy count, each commit fits in a few dozen cycles, which leaves time to inject strobes and toggle write protect inside the busy window.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Strobes from the control FSM to the page datapath.
  typedef struct packed {
    logic loadAddr;   // take startAddr into the pointer
    logic storeByte;  // stage byteData at the pointer, then step it
    logic clearMask;  // forget every staged byte
    logic startScan;  // begin the offset walk that writes the array
  } pgwr_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } pgwr_state_e;

endpackage

// File: rtl/pgwr_control.sv
module pgwr_control
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int BUSY_CYCLES = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       byteWr,
  input  logic       stopStrb,
  input  logic       cmdAbort,
  input  logic       wpIn,
  input  logic       anyLoaded,
  output pgwr_ctrl_t ctrl,
  output logic       busy
);

  // The walk over the page must finish inside the busy window.
  localparam int HOLD_CYC = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);

  pgwr_state_e state, stateNxt;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctrl.loadAddr  = 1'b1;
          ctrl.clearMask = 1'b1;
          stateNxt       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (stopStrb) begin
          // Write protect is looked at here and nowhere else.
          if (!wpIn && anyLoaded) begin
            ctrl.startScan = 1'b1;
            stateNxt       = ST_BUSY;
          end else begin
            ctrl.clearMask = 1'b1;
            stateNxt       = ST_IDLE;
          end
        end else if (cmdAbort) begin
          ctrl.clearMask = 1'b1;
          stateNxt       = ST_IDLE;
        end else if (cmdStart) begin
          ctrl.loadAddr  = 1'b1;
          ctrl.clearMask = 1'b1;
        end else if (byteWr) begin
          ctrl.storeByte = 1'b1;
        end
      end
      ST_BUSY: begin
        if (holdCnt == '0) begin
          ctrl.clearMask = 1'b1;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state <= stateNxt;
      if (ctrl.startScan) begin
        holdCnt <= CNT_W'(HOLD_CYC - 1);
      end else if (state == ST_BUSY && holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/pgwr_datapath.sv
module pgwr_datapath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwr_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              anyLoaded,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

  logic [ADDR_W-1:0]     ptr;
  logic [7:0]            pageMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic [OFS_W-1:0]      scanOfs;
  logic                  scanOn;

  logic [OFS_W-1:0]  wrOfs;
  logic [PAGE_W-1:0] pageBase;

  assign wrOfs    = ptr[OFS_W-1:0];
  assign pageBase = ptr[ADDR_W-1:OFS_W];

  // Pointer: only the in-page offset moves on a data byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctrl.loadAddr) begin
      ptr <= startAddr;
    end else if (ctrl.storeByte) begin
      ptr <= {pageBase, wrOfs + OFS_W'(1)};
    end
  end

  // Staging storage, no reset needed: the mask qualifies every entry.
  always_ff @(posedge clk) begin
    if (ctrl.storeByte) begin
      pageMem[wrOfs] <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded <= '0;
    end else if (ctrl.clearMask) begin
      loaded <= '0;
    end else if (ctrl.storeByte) begin
      loaded[wrOfs] <= 1'b1;
    end
  end

  // One pass over every offset, lowest first.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanOn  <= 1'b0;
      scanOfs <= '0;
    end else if (ctrl.startScan) begin
      scanOn  <= 1'b1;
      scanOfs <= '0;
    end else if (scanOn) begin
      scanOfs <= scanOfs + OFS_W'(1);
      if (scanOfs == LAST_OFS) begin
        scanOn <= 1'b0;
      end
    end
  end

  assign anyLoaded = |loaded;
  assign ptrOut    = ptr;
  assign arrWe     = scanOn & loaded[scanOfs];
  assign arrAddr   = {pageBase, scanOfs};
  assign arrData   = pageMem[scanOfs];

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BYTES  = 128,
  parameter int BUSY_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteWr,
  input  logic [7:0]        byteData,
  input  logic              stopStrb,
  input  logic              cmdAbort,
  input  logic              wpIn,
  output logic              busy,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData
);

  pgwr_ctrl_t ctrl;
  logic       anyLoaded;

  pgwr_control #(
    .PAGE_BYTES (PAGE_BYTES),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .byteWr   (byteWr),
    .stopStrb (stopStrb),
    .cmdAbort (cmdAbort),
    .wpIn     (wpIn),
    .anyLoaded(anyLoaded),
    .ctrl     (ctrl),
    .busy     (busy)
  );

  pgwr_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .startAddr(startAddr),
    .byteData (byteData),
    .ptrOut   (ptrOut),
    .anyLoaded(anyLoaded),
    .arrWe    (arrWe),
    .arrAddr  (arrAddr),
    .arrData  (arrData)
  );

endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              byteWr,
  input logic              stopStrb,
  input logic              cmdAbort,
  input logic              wpIn,
  input logic              busy,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic [ADDR_W-1:0] ptrOut
);

  localparam int OFS_W = $clog2(PAGE_BYTES);

  AST_WE_ONLY_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);  // R11

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStrb));  // R5

  AST_PROTECTED_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStrb && wpIn) |=> !busy);  // R7

  AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdAbort) |=> !busy);  // R8

  AST_PTR_HELD_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptrOut));  // R9

  AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (arrAddr[ADDR_W-1:OFS_W] == ptrOut[ADDR_W-1:OFS_W]));  // R6

  AST_PAGE_BITS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && !cmdStart && !stopStrb && !cmdAbort)
      |=> (ptrOut[ADDR_W-1:OFS_W] == $past(ptrOut[ADDR_W-1:OFS_W])));  // R3

endmodule

bind pgwr_commit pgwr_commit_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdStart(cmdStart),
  .byteWr  (byteWr),
  .stopStrb(stopStrb),
  .cmdAbort(cmdAbort),
  .wpIn    (wpIn),
  .busy    (busy),
  .arrWe   (arrWe),
  .arrAddr (arrAddr),
  .ptrOut  (ptrOut)
);

// File: tb/pgwr_commit_test.sv
module pgwr_commit_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int PG   = 16;
  localparam int OW   = 4;
  localparam int BUSY = 40;
  localparam int HOLD = (BUSY > PG) ? BUSY : PG;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdStart, byteWr, stopStrb, cmdAbort, wpIn;
  logic [AW-1:0] startAddr;
  logic [7:0]    byteData;
  logic          busy, arrWe;
  logic [AW-1:0] ptrOut, arrAddr;
  logic [7:0]    arrData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .PAGE_BYTES(PG), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .byteWr(byteWr), .byteData(byteData), .stopStrb(stopStrb),
    .cmdAbort(cmdAbort), .wpIn(wpIn), .busy(busy), .ptrOut(ptrOut),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Bench array mirror and expected image
  logic [7:0] arrMem [MEMN];
  logic [7:0] expMem [MEMN];
  int         wrCount;
  int         lastOfs;
  bit         orderBad;

  // Bench model of the staged command
  logic [7:0]    shBuf [PG];
  logic [PG-1:0] shMask;
  logic [AW-1:0] modelPtr;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return {p[AW-1:OW], p[OW-1:0] + OW'(1)};
  endfunction

  // Monitor of array writes, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN && arrWe) begin
      if (int'(arrAddr[OW-1:0]) <= lastOfs) orderBad = 1'b1;
      lastOfs = int'(arrAddr[OW-1:0]);
      arrMem[arrAddr] = arrData;
      wrCount++;
    end
  end

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doStart(input logic [AW-1:0] a);
    cmdStart = 1'b1; startAddr = a;
    @(negedge clk);
    cmdStart = 1'b0;
    modelPtr = a;
    shMask   = '0;
  endtask

  task automatic doByte(input logic [7:0] d);
    byteWr = 1'b1; byteData = d;
    @(negedge clk);
    byteWr = 1'b0;
    shBuf[modelPtr[OW-1:0]]  = d;
    shMask[modelPtr[OW-1:0]] = 1'b1;
    modelPtr = stepPtr(modelPtr);
  endtask

  task automatic doStop(input logic wp);
    wpIn = wp; stopStrb = 1'b1;
    @(negedge clk);
    stopStrb = 1'b0;
  endtask

  task automatic doAbort();
    cmdAbort = 1'b1;
    @(negedge clk);
    cmdAbort = 1'b0;
  endtask

  function automatic int memDiffs();
    int n = 0;
    for (int i = 0; i < MEMN; i++) if (arrMem[i] !== expMem[i]) n++;
    return n;
  endfunction

  // Runs until busy falls; optionally throws strobes and WP toggles at it.
  task automatic waitBusy(input bit poke, output int cnt);
    cnt = 0;
    while (busy === 1'b1 && cnt < 10 * HOLD) begin
      cnt++;
      if (poke) begin
        byteWr    = 1'b1;
        byteData  = 8'($urandom);
        cmdStart  = cnt[0];
        cmdAbort  = (cnt % 5) == 0;
        stopStrb  = (cnt % 7) == 0;
        startAddr = AW'($urandom);
        wpIn      = ~wpIn;
      end
      @(negedge clk);
    end
    byteWr = 1'b0; cmdStart = 1'b0; cmdAbort = 1'b0; stopStrb = 1'b0; wpIn = 1'b0;
  endtask

  task automatic runWrite(input logic [AW-1:0] a, input int n, input logic wp, input bit poke);
    bit            expCommit;
    int            cnt;
    logic [AW-1:0] ptrHold;
    doStart(a);
    for (int i = 0; i < n; i++) doByte(8'($urandom));
    expCommit = !wp && (n > 0);
    wrCount = 0; lastOfs = -1; orderBad = 1'b0;
    doStop(wp);
    check(ptrOut == modelPtr, "R3 pointer after bytes", ptrOut, modelPtr);
    check(busy == expCommit, (n == 0) ? "R10 busy after empty stop" :
          (wp ? "R7 busy after protected stop" : "R5 busy after stop"), busy, expCommit);
    if (expCommit) begin
      ptrHold = ptrOut;
      waitBusy(poke, cnt);
      check(cnt == HOLD, "R5 busy length", cnt, HOLD);
      for (int o = 0; o < PG; o++)
        if (shMask[o]) expMem[{modelPtr[AW-1:OW], OW'(o)}] = shBuf[o];
      check(wrCount == $countones(shMask), "R6 write count", wrCount, $countones(shMask));
      check(!orderBad, "R6 ascending offsets", orderBad, 0);
      check(memDiffs() == 0, (n > PG) ? "R4 array image after overflow" :
            "R6 array image", memDiffs(), 0);
      if (poke) check(ptrOut == ptrHold, "R9 pointer held through busy", ptrOut, ptrHold);
    end else begin
      idleCycles(HOLD + 2);
      check(wrCount == 0, wp ? "R7 no writes when protected" : "R10 no writes", wrCount, 0);
      check(busy == 1'b0, "R7 still idle", busy, 0);
      if (n == 0) check(ptrOut == a, "R10 pointer at start address", ptrOut, a);
    end
  endtask

  initial begin
    int rnd;
    for (int i = 0; i < MEMN; i++) begin arrMem[i] = 8'h00; expMem[i] = 8'h00; end
    rnd = int'($urandom(32'h5A17));
    rstN = 1'b0; cmdStart = 1'b0; byteWr = 1'b0; stopStrb = 1'b0; cmdAbort = 1'b0;
    wpIn = 1'b0; startAddr = '0; byteData = '0; shMask = '0; modelPtr = '0;
    wrCount = 0; lastOfs = -1; orderBad = 1'b0;
    idleCycles(4);
    check(busy == 1'b0, "R1 busy at reset", busy, 0);
    check(arrWe == 1'b0, "R1 arrWe at reset", arrWe, 0);
    check(ptrOut == '0, "R1 pointer at reset", ptrOut, 0);
    rstN = 1'b1;
    idleCycles(2);

    // R2: start address lands in the pointer
    doStart(12'h5A3);
    check(ptrOut == 12'h5A3, "R2 pointer loaded", ptrOut, 12'h5A3);
    doAbort();

    // Single byte write
    runWrite(12'h123, 1, 1'b0, 1'b0);
    // Wrap inside the page from offset 14
    runWrite(12'h24E, 5, 1'b0, 1'b0);
    // Overflow past a full page
    runWrite(12'h3A7, PG + 5, 1'b0, 1'b0);
    // Exactly one full page: pointer returns to start
    runWrite(12'h410, PG, 1'b0, 1'b0);
    check(ptrOut == 12'h410, "R3 full page pointer wraps home", ptrOut, 12'h410);
    // Protected write
    runWrite(12'h500, 6, 1'b1, 1'b0);
    // Address-only command
    runWrite(12'h6C5, 0, 1'b0, 1'b0);
    // Strobes and WP toggles during busy
    runWrite(12'h702, 9, 1'b0, 1'b1);

    // R8: abort before stop
    doStart(12'h834);
    for (int i = 0; i < 7; i++) doByte(8'($urandom));
    wrCount = 0;
    doAbort();
    idleCycles(HOLD + 2);
    check(busy == 1'b0, "R8 no busy after abort", busy, 0);
    check(wrCount == 0, "R8 no writes after abort", wrCount, 0);
    check(ptrOut == modelPtr, "R8 pointer kept after abort", ptrOut, modelPtr);
    // Fresh command on same page: only its own bytes are written
    runWrite(12'h830, 2, 1'b0, 1'b0);

    // R8: new start before stop drops the first set of bytes
    doStart(12'h900);
    for (int i = 0; i < 6; i++) doByte(8'($urandom));
    runWrite(12'h904, 3, 1'b0, 1'b0);
    check(memDiffs() == 0, "R8 restarted bytes not written", memDiffs(), 0);

    // Random phase
    for (int k = 0; k < 20; k++) begin
      runWrite(AW'($urandom), int'($urandom_range(0, 2 * PG)),
               ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL R5 watchdog expired: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule